// File: doc/BRIEF.md
# Ping-Pong Frame Capture Controller

This block moves an 8-bit pixel stream out of a line FIFO and into a two-bank frame memory. One bank collects the frame that is arriving. The other bank keeps the last complete frame for a downstream reader. Pixels move in whole-line bursts. A burst starts only when the FIFO reports that it holds a complete line.

When the final pixel of the final line has been written, the two banks swap roles in one step. The reader is then told, with a single-cycle pulse, that a fresh frame is waiting. The bank the reader may use is shown on a dedicated output. That output changes only at the swap, so a consumer can latch it on the pulse and work undisturbed for a whole frame period.

The line length and the lines per frame are parameters; both default to 512. The FIFO is of the show-ahead kind: its head word is on the data input whenever it is not empty, and a read strobe pops it.

Top module: `pp_capture`

## Requirements
- R1: While rst_ni is low, fifo_rd_o, mem_we_o and frame_ready_o are 0 and rd_bank_o is 1. Capture therefore starts in bank 0, and the line and pixel counters start at 0.
- R2: Whenever fifo_rd_o is low in a cycle, fifo_rd_o in the next cycle equals the line_avail_i value sampled at the edge between them. Once a burst starts, fifo_rd_o stays high for exactly LINE_LEN consecutive cycles.
- R3: In every cycle with fifo_rd_o high, mem_we_o is high and mem_data_o equals fifo_data_i. In all other cycles, mem_we_o is low.
- R4: mem_addr_o is {capture bank (MSB), line index, pixel index (LSBs)}. The pixel index takes LINE_CW = clog2(LINE_LEN) bits and the line index takes FRAME_CW = clog2(NUM_LINES) bits. Both indices count up from 0 through a frame, in arrival order.
- R5: In the cycle after the write of the final pixel of the final line, frame_ready_o is high for exactly one cycle and rd_bank_o has inverted. rd_bank_o holds its value in every other cycle.
- R6: line_avail_i has no effect while a burst is running. After every burst there is exactly one idle cycle, in which line_avail_i is sampled again. A line that completed during a burst is therefore taken in the next burst, with no line lost or duplicated.
- R7: A write never addresses the bank shown on rd_bank_o.
- R8: After a swap, the next write goes to line 0, pixel 0 of the newly selected capture bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_avail_i | input | 1 | FIFO holds at least one full line |
| fifo_data_i | input | PIX_W | FIFO head pixel (show-ahead) |
| fifo_rd_o | output | 1 | FIFO pop strobe |
| mem_we_o | output | 1 | Frame memory write enable |
| mem_addr_o | output | 1+FRAME_CW+LINE_CW | Frame memory address {bank, line, pixel} |
| mem_data_o | output | PIX_W | Frame memory write data |
| rd_bank_o | output | 1 | Bank holding the stable frame for the reader |
| frame_ready_o | output | 1 | One-cycle new-frame pulse |

## Verification
Each result has a fixed delay, and the bench checks it at that delay:

- **Memory write:** a write appears in the same cycle as its FIFO pop.
- **Burst start:** a burst begins one cycle after line_avail_i is sampled high in an idle cycle.
- **Swap:** the frame-ready pulse and the bank flip appear one cycle after the final write of a frame.

The bench samples every output on the falling edge. It predicts each cycle's pop strobe from the previous cycle's strobe, the flag value the design saw at the rising edge, and its own count of pops in the current burst. Expected addresses and data are queued as pixels enter the bench's FIFO model, and each write pops and compares one entry. The frame-ready pulse and the bank value are compared on the cycle after each write that completes a frame, and on every other cycle as well.

// File: rtl/pp_capture_pkg.sv
package pp_capture_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } cap_state_e;
endpackage

// File: rtl/pp_burst_ctrl.sv
module pp_burst_ctrl
  import pp_capture_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_avail_i,
  input  logic line_end_i,
  output logic burst_o
);
  cap_state_e state_q, state_d;

  // The idle state is held for at least one cycle after each burst, so the
  // flag is re-read only once the FIFO level has settled.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (line_avail_i) state_d = ST_BURST;
      ST_BURST: if (line_end_i)   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign burst_o = (state_q == ST_BURST);
endmodule

// File: rtl/pp_addr_gen.sv
module pp_addr_gen #(
  parameter int LINE_LEN  = 512,
  parameter int NUM_LINES = 512,
  localparam int LINE_CW  = (LINE_LEN  > 1) ? $clog2(LINE_LEN)  : 1,
  localparam int FRAME_CW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  output logic [LINE_CW-1:0]  pix_idx_o,
  output logic [FRAME_CW-1:0] line_idx_o,
  output logic                cap_bank_o,
  output logic                line_end_o,
  output logic                frame_end_o
);
  localparam logic [LINE_CW-1:0]  PIX_MAX  = LINE_CW'(LINE_LEN - 1);
  localparam logic [FRAME_CW-1:0] LINE_MAX = FRAME_CW'(NUM_LINES - 1);

  logic [LINE_CW-1:0]  pix_q;
  logic [FRAME_CW-1:0] line_q;
  logic                bank_q;
  logic                pix_last, line_last;

  assign pix_last  = (pix_q == PIX_MAX);
  assign line_last = (line_q == LINE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      line_q <= '0;
      bank_q <= 1'b0;
    end else if (step_i) begin
      if (!pix_last) begin
        pix_q <= pix_q + 1'b1;
      end else begin
        pix_q <= '0;
        if (!line_last) begin
          line_q <= line_q + 1'b1;
        end else begin
          line_q <= '0;
          bank_q <= ~bank_q;
        end
      end
    end
  end

  assign pix_idx_o   = pix_q;
  assign line_idx_o  = line_q;
  assign cap_bank_o  = bank_q;
  assign line_end_o  = step_i && pix_last;
  assign frame_end_o = step_i && pix_last && line_last;
endmodule

// File: rtl/pp_capture.sv
module pp_capture #(
  parameter int PIX_W     = 8,
  parameter int LINE_LEN  = 512,
  parameter int NUM_LINES = 512,
  localparam int LINE_CW  = (LINE_LEN  > 1) ? $clog2(LINE_LEN)  : 1,
  localparam int FRAME_CW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int ADDR_W   = 1 + FRAME_CW + LINE_CW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_avail_i,
  input  logic [PIX_W-1:0]  fifo_data_i,
  output logic              fifo_rd_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PIX_W-1:0]  mem_data_o,
  output logic              rd_bank_o,
  output logic              frame_ready_o
);
  logic                burst;
  logic                line_end, frame_end;
  logic [LINE_CW-1:0]  pix_idx;
  logic [FRAME_CW-1:0] line_idx;
  logic                cap_bank;
  logic                ready_q;

  pp_burst_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_avail_i (line_avail_i),
    .line_end_i   (line_end),
    .burst_o      (burst)
  );

  pp_addr_gen #(
    .LINE_LEN  (LINE_LEN),
    .NUM_LINES (NUM_LINES)
  ) i_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (burst),
    .pix_idx_o   (pix_idx),
    .line_idx_o  (line_idx),
    .cap_bank_o  (cap_bank),
    .line_end_o  (line_end),
    .frame_end_o (frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= frame_end;
  end

  // Show-ahead FIFO: the head word is written in the same cycle it is popped.
  assign fifo_rd_o     = burst;
  assign mem_we_o      = burst;
  assign mem_data_o    = fifo_data_i;
  assign mem_addr_o    = {cap_bank, line_idx, pix_idx};
  assign rd_bank_o     = ~cap_bank;
  assign frame_ready_o = ready_q;
endmodule

// File: rtl/pp_capture_chk.sv
module pp_capture_chk #(
  parameter int LINE_LEN = 512,
  parameter int LINE_CW  = 9,
  parameter int ADDR_W   = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_avail_i,
  input logic              fifo_rd_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rd_bank_o,
  input logic              frame_ready_o
);
  localparam logic [LINE_CW-1:0] PIX_MAX = LINE_CW'(LINE_LEN - 1);

  assert_no_write_to_read_bank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[ADDR_W-1] != rd_bank_o));

  assert_ready_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |=> !frame_ready_o);

  assert_bank_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |-> (rd_bank_o != $past(rd_bank_o)));

  assert_bank_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ready_o |-> $stable(rd_bank_o));

  assert_start_on_avail_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_rd_o) |-> $past(line_avail_i));

  assert_burst_from_pixel0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_rd_o) |-> (mem_addr_o[LINE_CW-1:0] == '0));

  assert_gap_after_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rd_o && mem_addr_o[LINE_CW-1:0] == PIX_MAX) |=> !fifo_rd_o);
endmodule

bind pp_capture pp_capture_chk #(
  .LINE_LEN (LINE_LEN),
  .LINE_CW  (LINE_CW),
  .ADDR_W   (ADDR_W)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .line_avail_i  (line_avail_i),
  .fifo_rd_o     (fifo_rd_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .rd_bank_o     (rd_bank_o),
  .frame_ready_o (frame_ready_o)
);

// File: tb/test_pp_capture.sv
module test_pp_capture;
  localparam int PIX_W    = 8;
  localparam int LLEN     = 8;
  localparam int NLINES   = 4;
  localparam int LCW      = 3;
  localparam int FCW      = 2;
  localparam int AW       = 1 + FCW + LCW;
  localparam int FRAME_PX = LLEN * NLINES;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             line_avail;
  logic [PIX_W-1:0] fifo_data;
  logic             fifo_rd, mem_we, rd_bank, frame_ready;
  logic [AW-1:0]    mem_addr;
  logic [PIX_W-1:0] mem_data;

  always #5 clk = ~clk;

  pp_capture #(.PIX_W(PIX_W), .LINE_LEN(LLEN), .NUM_LINES(NLINES)) i_pp_capture (
    .clk_i(clk), .rst_ni(rst_n), .line_avail_i(line_avail), .fifo_data_i(fifo_data),
    .fifo_rd_o(fifo_rd), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .rd_bank_o(rd_bank), .frame_ready_o(frame_ready)
  );

  int tests = 0;
  int fails = 0;

  logic [PIX_W-1:0]      fifo_q[$];
  logic [AW+PIX_W-1:0]   exp_q[$];
  int  pushed = 0;
  int  prod_remaining = 0;
  int  prod_gap = 0;
  int  gap_cnt = 0;
  int  writes = 0;
  int  run_len = 0;
  int  frames_seen = 0;
  bit  prev_rd = 1'b0;
  bit  ready_due = 1'b0;
  bit  exp_bank = 1'b1;
  bit  running = 1'b0;

  assign line_avail = (fifo_q.size() >= LLEN);
  assign fifo_data  = (fifo_q.size() > 0) ? fifo_q[0] : '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: queue the expected write for every pixel entering the FIFO
  task automatic push_pixel();
    logic [PIX_W-1:0] d;
    logic [AW-1:0]    a;
    d = PIX_W'(pushed * 7 + 3);
    a = {1'(pushed / FRAME_PX), FCW'((pushed / LLEN) % NLINES), LCW'(pushed % LLEN)};
    fifo_q.push_back(d);
    exp_q.push_back({a, d});
    pushed++;
  endtask

  // Monitor and FIFO model, all on the falling edge
  always @(negedge clk) begin
    if (running) begin
      bit exp_rd;
      // R2 / R6: predict the pop strobe from the previous cycle
      if (!prev_rd) exp_rd = line_avail;
      else          exp_rd = (run_len < LLEN);
      check(fifo_rd == exp_rd, prev_rd ? "R6" : "R2", "fifo_rd_o", fifo_rd, exp_rd);
      check(mem_we == fifo_rd, "R3", "mem_we_o", mem_we, fifo_rd);
      // R5: pulse and bank flip one cycle after the final write
      check(frame_ready == ready_due, "R5", "frame_ready_o", frame_ready, ready_due);
      if (ready_due) begin
        exp_bank = ~exp_bank;
        frames_seen++;
      end
      check(rd_bank == exp_bank, "R5", "rd_bank_o", rd_bank, exp_bank);
      ready_due = 1'b0;
      if (fifo_rd) begin
        logic [AW+PIX_W-1:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
        // R4 / R8: address layout and restart after swap; R3: data
        check(mem_addr == e[AW+PIX_W-1:PIX_W], "R4", "mem_addr_o",
              mem_addr, e[AW+PIX_W-1:PIX_W]);
        check(mem_data == e[PIX_W-1:0], "R3", "mem_data_o", mem_data, e[PIX_W-1:0]);
        check(mem_addr[AW-1] != rd_bank, "R7", "write bank", mem_addr[AW-1], !rd_bank);
        if (writes % FRAME_PX == 0 && writes > 0)
          check(mem_addr[AW-2:0] == '0, "R8", "first addr after swap", mem_addr[AW-2:0], 0);
        writes++;
        if (writes % FRAME_PX == 0) ready_due = 1'b1;
        void'(fifo_q.pop_front());
        run_len = prev_rd ? run_len + 1 : 1;
      end else begin
        run_len = 0;
      end
      prev_rd = fifo_rd;
    end
    // Producer
    if (prod_remaining > 0) begin
      if (gap_cnt == 0) begin
        push_pixel();
        prod_remaining--;
        gap_cnt = prod_gap;
      end else begin
        gap_cnt--;
      end
    end
  end

  task automatic produce(input int n, input int gap);
    prod_gap = gap;
    gap_cnt = 0;
    prod_remaining = n;
    while (prod_remaining > 0) @(posedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while ((fifo_q.size() >= LLEN || fifo_rd) && guard < 1000) begin
      @(posedge clk);
      guard++;
    end
    repeat (4) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(fifo_rd == 1'b0, "R1", "fifo_rd_o in reset", fifo_rd, 0);
    check(mem_we == 1'b0, "R1", "mem_we_o in reset", mem_we, 0);
    check(frame_ready == 1'b0, "R1", "frame_ready_o in reset", frame_ready, 0);
    check(rd_bank == 1'b1, "R1", "rd_bank_o in reset", rd_bank, 1);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // Slow source: lines arrive singly with gaps
    produce(FRAME_PX, 2);
    drain();
    // Full-rate source: backlog builds, lines are back to back
    produce(2 * FRAME_PX, 0);
    drain();
    // Partial line held: flag stays low, nothing must be read
    produce(LLEN - 1, 0);
    repeat (20) @(posedge clk);
    check(fifo_q.size() == LLEN - 1, "R2", "partial line untouched",
          fifo_q.size(), LLEN - 1);
    // Completing the line plus mixed rate for the rest
    produce(FRAME_PX + 1, 1);
    drain();
    produce(FRAME_PX, 0);
    drain();
    check(frames_seen == 5, "R5", "frames announced", frames_seen, 5);
    check(exp_q.size() == 0, "R6", "lines left unwritten", exp_q.size(), 0);
    check(writes == pushed, "R6", "total writes", writes, pushed);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule